// File: doc/BRIEF.md
# Secondary-Clock Idle Sequencer

This block sequences the clock enables of a small microcontroller through a low-power idle mode. In that mode the processor clock stops and the peripherals keep running from a slow secondary oscillator. The processor asks for the mode by pulsing a sleep strobe. The request is honoured only when idle is enabled, the clock-select field asks for the secondary source, and the secondary oscillator is enabled. Every other sleep strobe leaves the block as it was.

A wake event starts the primary oscillator again and, after a fixed delay counted in clock cycles, restarts the processor clock from the secondary source. The processor runs from that slow clock while a start-up counter counts primary-oscillator ticks. The counter needs one fixed span, plus a second span when the PLL is in use. Once the primary source is ready, the block stops both enables for one cycle, moves the source select back to the primary clock, and updates two status flags. Before any change of source the block holds both enables low for at least one cycle, so no partial pulse reaches the logic.

Top module: `pmseq_top`

## Requirements
- R1: After a synchronous active-high reset, the block is in primary run: cpuClkEn=1, perClkEn=1, clkSrcSec=0 (0 selects primary, 1 selects secondary), priOscEn=1, priStable=1, secActive=0.
- R2: In primary run, a sleepStrobe with idleEn=1, clkSel=2'b01 and secOscEn=1 drops both cpuClkEn and perClkEn on the next cycle while clkSrcSec is still 0. A strobe with idleEn=0 or clkSel other than 2'b01 changes no output.
- R3: A sleepStrobe that arrives with secOscEn=0 is ignored. The block stays in primary run with all outputs unchanged.
- R4: One cycle after the gating cycle of R2, clkSrcSec=1, priOscEn=0, priStable=0 and secActive=1.
- R5: While secOscRunning=0, perClkEn stays low. It rises on the cycle after secOscRunning is seen high.
- R6: In secondary idle, cpuClkEn=0 and perClkEn=1.
- R7: After a wakeEvent is sampled in secondary idle, cpuClkEn stays low for WAKE_CYC cycles and then rises with clkSrcSec still 1.
- R8: priOscEn returns to 1 on the cycle after the wakeEvent is sampled, and the start-up count restarts from zero at that point.
- R9: The processor keeps running from the secondary source until priOscTick has been seen OST_CYC times since the wake, or OST_CYC+PLL_CYC times when pllSel=1.
- R10: The switch back takes one cycle with both enables low. The next cycle shows clkSrcSec=0, priStable=1, secActive=0 and both enables high, and priOscEn stays 1.
- R11: clkSrcSec changes only after a cycle in which cpuClkEn and perClkEn were both low.
- R12: A wakeEvent in primary run has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| sleepStrobe | input | 1 | One-cycle sleep request from the processor |
| idleEn | input | 1 | Idle-mode enable bit |
| clkSel | input | 2 | Clock-select field; 2'b01 requests the secondary source |
| secOscEn | input | 1 | Secondary oscillator enabled |
| secOscRunning | input | 1 | Secondary oscillator running and usable |
| pllSel | input | 1 | Primary path uses the PLL, which adds the lock interval |
| priOscTick | input | 1 | One pulse per primary-oscillator start-up tick |
| wakeEvent | input | 1 | Wake request |
| cpuClkEn | output | 1 | Processor clock enable |
| perClkEn | output | 1 | Peripheral clock enable |
| clkSrcSec | output | 1 | Clock source select, 1 = secondary |
| priOscEn | output | 1 | Primary oscillator enable |
| priStable | output | 1 | Status: primary clock drives the system |
| secActive | output | 1 | Status: secondary clock drives the system |

## Verification
The hardest path to reach is the full round trip with the PLL: sleep, a held-off peripheral clock, wake, the timed delay, and a secondary-run period that must last exactly OST_CYC+PLL_CYC ticks. The bench drives the secondary running flag low for several cycles after entry, then pulses wake. It then steps an exact number of cycles derived from the parameters, so the last cycle on the secondary source and the gating cycle are each sampled on their own. Rejected sleep strobes and a stray wake are checked at every output on the next cycle.

// File: rtl/pmseq_pkg.sv
package pmseq_pkg;

  typedef enum logic [2:0] {
    ST_PRI_RUN,
    ST_GATE_IN,
    ST_SEC_WAIT,
    ST_SEC_IDLE,
    ST_WAKE_DLY,
    ST_SEC_RUN,
    ST_GATE_OUT
  } pmState_t;

  typedef struct packed {
    logic gateToSec;
    logic wakeStart;
    logic countWake;
    logic gateToPri;
  } ctlStrobes_t;

endpackage

// File: rtl/pmseq_ctrl.sv
module pmseq_ctrl
  import pmseq_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        sleepStrobe,
  input  logic        idleEn,
  input  logic [1:0]  clkSel,
  input  logic        secOscEn,
  input  logic        secOscRunning,
  input  logic        wakeEvent,
  input  logic        wakeDone,
  input  logic        priRdy,
  output ctlStrobes_t strobes,
  output logic        cpuClkEn,
  output logic        perClkEn
);

  localparam logic [1:0] SEL_SECONDARY = 2'b01;

  pmState_t state, stateNext;
  logic     enterIdle;

  assign enterIdle = sleepStrobe && idleEn && (clkSel == SEL_SECONDARY) && secOscEn;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_PRI_RUN:  if (enterIdle)     stateNext = ST_GATE_IN;
      ST_GATE_IN:                     stateNext = ST_SEC_WAIT;
      ST_SEC_WAIT: if (secOscRunning) stateNext = ST_SEC_IDLE;
      ST_SEC_IDLE: if (wakeEvent)     stateNext = ST_WAKE_DLY;
      ST_WAKE_DLY: if (wakeDone)      stateNext = ST_SEC_RUN;
      ST_SEC_RUN:  if (priRdy)        stateNext = ST_GATE_OUT;
      ST_GATE_OUT:                    stateNext = ST_PRI_RUN;
      default:                        stateNext = ST_PRI_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_PRI_RUN;
    else     state <= stateNext;
  end

  always_comb begin
    strobes.gateToSec = (state == ST_GATE_IN);
    strobes.wakeStart = (state == ST_SEC_IDLE) && wakeEvent;
    strobes.countWake = (state == ST_WAKE_DLY);
    strobes.gateToPri = (state == ST_GATE_OUT);
  end

  always_comb begin
    cpuClkEn = (state == ST_PRI_RUN) || (state == ST_SEC_RUN);
    perClkEn = (state == ST_PRI_RUN) || (state == ST_SEC_RUN) ||
               (state == ST_SEC_IDLE) || (state == ST_WAKE_DLY);
  end

  AST_WAKE_HOLDS_CPU: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SEC_IDLE && wakeEvent) |=> !cpuClkEn && perClkEn); // R7

endmodule

// File: rtl/pmseq_dp.sv
module pmseq_dp
  import pmseq_pkg::*;
#(
  parameter int WAKE_CYC = 10,
  parameter int OST_CYC  = 1024,
  parameter int PLL_CYC  = 2048
) (
  input  logic        clk,
  input  logic        rst,
  input  ctlStrobes_t strobes,
  input  logic        pllSel,
  input  logic        priOscTick,
  output logic        wakeDone,
  output logic        priRdy,
  output logic        clkSrcSec,
  output logic        priOscEn,
  output logic        priStable,
  output logic        secActive
);

  localparam int WK_W = $clog2(WAKE_CYC + 1);
  localparam int ST_W = $clog2(OST_CYC + PLL_CYC + 1);
  localparam logic [WK_W-1:0] WAKE_LOAD = WK_W'(WAKE_CYC - 1);
  localparam logic [ST_W-1:0] OST_VAL   = ST_W'(OST_CYC);
  localparam logic [ST_W-1:0] FULL_VAL  = ST_W'(OST_CYC + PLL_CYC);

  logic [WK_W-1:0] wakeCnt;
  logic [ST_W-1:0] startCnt;
  logic [ST_W-1:0] startTarget;

  assign startTarget = pllSel ? FULL_VAL : OST_VAL;
  assign priRdy      = priOscEn && (startCnt >= startTarget);
  assign wakeDone    = (wakeCnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      clkSrcSec <= 1'b0;
      priOscEn  <= 1'b1;
      priStable <= 1'b1;
      secActive <= 1'b0;
    end else if (strobes.gateToSec) begin
      clkSrcSec <= 1'b1;
      priOscEn  <= 1'b0;
      priStable <= 1'b0;
      secActive <= 1'b1;
    end else if (strobes.gateToPri) begin
      clkSrcSec <= 1'b0;
      priStable <= 1'b1;
      secActive <= 1'b0;
    end else if (strobes.wakeStart) begin
      priOscEn  <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wakeCnt <= '0;
    end else if (strobes.wakeStart) begin
      wakeCnt <= WAKE_LOAD;
    end else if (strobes.countWake && !wakeDone) begin
      wakeCnt <= wakeCnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || strobes.wakeStart || !priOscEn) begin
      startCnt <= '0;
    end else if (priOscTick && (startCnt < FULL_VAL)) begin
      startCnt <= startCnt + 1'b1;
    end
  end

  AST_SWITCH_AFTER_STARTUP: assert property (@(posedge clk) disable iff (rst)
    $fell(clkSrcSec) |-> $past(priRdy, 2)); // R9

endmodule

// File: rtl/pmseq_top.sv
module pmseq_top
  import pmseq_pkg::*;
#(
  parameter int WAKE_CYC = 10,
  parameter int OST_CYC  = 1024,
  parameter int PLL_CYC  = 2048
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sleepStrobe,
  input  logic       idleEn,
  input  logic [1:0] clkSel,
  input  logic       secOscEn,
  input  logic       secOscRunning,
  input  logic       pllSel,
  input  logic       priOscTick,
  input  logic       wakeEvent,
  output logic       cpuClkEn,
  output logic       perClkEn,
  output logic       clkSrcSec,
  output logic       priOscEn,
  output logic       priStable,
  output logic       secActive
);

  ctlStrobes_t strobes;
  logic        wakeDone;
  logic        priRdy;

  pmseq_ctrl i_ctrl (
    .clk           (clk),
    .rst           (rst),
    .sleepStrobe   (sleepStrobe),
    .idleEn        (idleEn),
    .clkSel        (clkSel),
    .secOscEn      (secOscEn),
    .secOscRunning (secOscRunning),
    .wakeEvent     (wakeEvent),
    .wakeDone      (wakeDone),
    .priRdy        (priRdy),
    .strobes       (strobes),
    .cpuClkEn      (cpuClkEn),
    .perClkEn      (perClkEn)
  );

  pmseq_dp #(
    .WAKE_CYC (WAKE_CYC),
    .OST_CYC  (OST_CYC),
    .PLL_CYC  (PLL_CYC)
  ) i_dp (
    .clk        (clk),
    .rst        (rst),
    .strobes    (strobes),
    .pllSel     (pllSel),
    .priOscTick (priOscTick),
    .wakeDone   (wakeDone),
    .priRdy     (priRdy),
    .clkSrcSec  (clkSrcSec),
    .priOscEn   (priOscEn),
    .priStable  (priStable),
    .secActive  (secActive)
  );

  AST_SRC_GATED: assert property (@(posedge clk) disable iff (rst)
    (clkSrcSec != $past(clkSrcSec)) |-> $past(!cpuClkEn && !perClkEn)); // R11

  AST_STROBE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (sleepStrobe && !secOscEn && cpuClkEn && !clkSrcSec) |=> cpuClkEn && !clkSrcSec); // R3

  AST_PER_WAITS_OSC: assert property (@(posedge clk) disable iff (rst)
    ($rose(perClkEn) && clkSrcSec) |-> $past(secOscRunning)); // R5

  AST_PRI_ON_AT_WAKE: assert property (@(posedge clk) disable iff (rst)
    $rose(priOscEn) |-> $past(wakeEvent)); // R8

endmodule

// File: tb/test_pmseq_top.sv
module test_pmseq_top;

  localparam int WAKE = 10;
  localparam int OST  = 1024;
  localparam int PLL  = 2048;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sleepStrobe = 1'b0;
  logic       idleEn = 1'b0;
  logic [1:0] clkSel = 2'b00;
  logic       secOscEn = 1'b0;
  logic       secOscRunning = 1'b0;
  logic       pllSel = 1'b0;
  logic       priOscTick = 1'b1;
  logic       wakeEvent = 1'b0;
  logic       cpuClkEn, perClkEn, clkSrcSec, priOscEn, priStable, secActive;

  int nChecks = 0;
  int nFails  = 0;

  always #5 clk = ~clk;

  pmseq_top #(.WAKE_CYC(WAKE), .OST_CYC(OST), .PLL_CYC(PLL)) i_pmseq_top (
    .clk(clk), .rst(rst), .sleepStrobe(sleepStrobe), .idleEn(idleEn),
    .clkSel(clkSel), .secOscEn(secOscEn), .secOscRunning(secOscRunning),
    .pllSel(pllSel), .priOscTick(priOscTick), .wakeEvent(wakeEvent),
    .cpuClkEn(cpuClkEn), .perClkEn(perClkEn), .clkSrcSec(clkSrcSec),
    .priOscEn(priOscEn), .priStable(priStable), .secActive(secActive)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int outVec();
    return {cpuClkEn, perClkEn, clkSrcSec, priOscEn, priStable, secActive};
  endfunction

  localparam int PRI_RUN_VEC = 6'b110110;

  task automatic t_reset();
    rst = 1'b1;
    step(2);
    rst = 1'b0;
    step(1);
    chk("R1", "outputs after reset", outVec(), PRI_RUN_VEC);
  endtask

  task automatic t_rejected();
    secOscEn = 1'b1; idleEn = 1'b0; clkSel = 2'b01; sleepStrobe = 1'b1;
    step(1);
    chk("R2", "idleEn=0 strobe", outVec(), PRI_RUN_VEC);
    idleEn = 1'b1; clkSel = 2'b10;
    step(1);
    chk("R2", "clkSel=10 strobe", outVec(), PRI_RUN_VEC);
    clkSel = 2'b00;
    step(1);
    chk("R2", "clkSel=00 strobe", outVec(), PRI_RUN_VEC);
    clkSel = 2'b01; secOscEn = 1'b0;
    step(1);
    chk("R3", "secOscEn=0 strobe", outVec(), PRI_RUN_VEC);
    sleepStrobe = 1'b0;
    step(2);
    chk("R3", "still primary run", outVec(), PRI_RUN_VEC);
    wakeEvent = 1'b1;
    step(1);
    wakeEvent = 1'b0;
    chk("R12", "wake in primary run", outVec(), PRI_RUN_VEC);
    step(1);
    chk("R12", "wake in primary run, later", outVec(), PRI_RUN_VEC);
  endtask

  task automatic t_roundTrip(input bit usePll, input int oscLag);
    int target;
    target = OST + (usePll ? PLL : 0);
    pllSel = usePll; idleEn = 1'b1; clkSel = 2'b01; secOscEn = 1'b1;
    secOscRunning = (oscLag == 0);
    sleepStrobe = 1'b1;
    step(1);
    sleepStrobe = 1'b0;
    chk("R2", "gate-in enables", {cpuClkEn, perClkEn}, 0);
    chk("R2", "source before switch", clkSrcSec, 0);
    step(1);
    chk("R4", "entry flags", {clkSrcSec, priOscEn, priStable, secActive}, 4'b1001);
    if (oscLag > 0) begin
      step(oscLag);
      chk("R5", "peripheral held while osc not running", perClkEn, 0);
      secOscRunning = 1'b1;
    end
    step(1);
    chk("R6", "idle enables", {cpuClkEn, perClkEn}, 2'b01);
    step(3);
    chk("R6", "idle enables, steady", {cpuClkEn, perClkEn}, 2'b01);
    chk("R5", "peripheral running after osc ready", perClkEn, 1);
    wakeEvent = 1'b1;
    step(1);
    wakeEvent = 1'b0;
    chk("R8", "primary osc enabled at wake", priOscEn, 1);
    chk("R7", "cpu off at wake", cpuClkEn, 0);
    step(WAKE - 1);
    chk("R7", "cpu off at end of delay", cpuClkEn, 0);
    step(1);
    chk("R7", "cpu on secondary after delay", {cpuClkEn, perClkEn, clkSrcSec}, 3'b111);
    step(target - WAKE);
    chk("R9", "last secondary-run cycle", {cpuClkEn, clkSrcSec, secActive}, 3'b111);
    step(1);
    chk("R10", "switch-back gate", {cpuClkEn, perClkEn, clkSrcSec}, 3'b001);
    chk("R11", "source held while gated", clkSrcSec, 1);
    step(1);
    chk("R10", "back in primary run", outVec(), PRI_RUN_VEC);
    step(1);
  endtask

  initial begin
    t_reset();
    t_rejected();
    t_roundTrip(1'b0, 0);
    t_roundTrip(1'b0, 4);
    t_roundTrip(1'b1, 3);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule